// File: doc/BRIEF.md
# I2C Slave Bridge to a 24-bit Word Array

This block is an I2C slave that lets an external bus master read and write a local array of 24-bit words. Every word crosses the bus as three bytes, most significant byte first. An internal word pointer advances after each whole word, so one transaction can move a run of consecutive words. A single byte can still be moved on its own.

The bus is handled on a system clock of 10 MHz or more. SCL and SDA are brought into that clock domain through two-flop synchronizers, and every bus event is found by comparing synchronized samples. SDA has two pins: a receive pin and an open-drain style transmit pin. The two pins can be joined to form one shared line, or they can be routed separately through isolators.

The 7-bit slave address has two parts. The upper part comes from a software-written address field. The lower part comes from strap pins. A parameter sets whether one or two strap pins are used.

Top module: `i2c24_bridge`

## Requirements
- R1: The slave address is the concatenation {dev_addr, strap}. With NARROW_PINS=0, dev_addr gives address bits 6..2 and strap gives bits 1..0. With NARROW_PINS=1, dev_addr gives bits 6..1 and strap gives bit 0.
- R2: After a START, the first byte holds the 7-bit address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The block pulls sda_o low in the ninth clock only when the address matches. On a mismatch it leaves sda_o released and ignores the bus until the next START.
- R3: In a write, the byte after the address loads the word pointer. Each later byte is ACKed. Bytes are packed most significant first, and the 24-bit word is written to the array only when its third byte arrives.
- R4: The word pointer increments after each complete word, whether written or read. It wraps from DEPTH-1 to 0.
- R5: If a write word has fewer than three bytes when a STOP or START arrives, it is discarded and the array is left unchanged.
- R6: A read sends the word at the pointer as three bytes, most significant byte and most significant bit first. A master ACK continues the transfer, moving to the next byte or word. A master NACK ends it, and sda_o stays released.
- R7: A STOP or START returns the block to its idle or address state from any state and releases sda_o. A read after a repeated START begins with the upper byte of the word at the current pointer.
- R8: sda_o uses 1 for released and 0 for pull-low. It is 1 after reset and while idle, and it only goes low while SCL is low.
- R9: The array holds DEPTH words of WORD_W bits (256 × 24 by default). Each word keeps the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 MHz |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Bus data, receive side |
| sda_o | output | 1 | Bus data, transmit side (0 pulls the line low, 1 releases it) |
| dev_addr | input | DEV_W (5) | Upper slave-address bits, written by software |
| strap | input | STRAP_W (2) | Lower slave-address bits, from strap pins |

## Verification
On every cycle, the assertions check these relations:
- sda_o is released after reset and after any START or STOP.
- sda_o is only pulled low while SCL is low.
- Every array write is a single-cycle pulse that happens while SCL is low.
- The pointer has already moved one word past the written slot when the write lands.

Only the bench scenarios can show the end-to-end bus behaviour: which addresses are acknowledged across the whole 7-bit space, the byte order, the pointer wrapping inside a burst, partial words being dropped, and a NACK ending a read.

// File: rtl/i2c24_pkg.sv
package i2c24_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WPTR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } bus_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c24_sync.sv
module i2c24_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] s1, s2, s3;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          s1[g] <= 1'b1;
          s2[g] <= 1'b1;
          s3[g] <= 1'b1;
        end else begin
          s1[g] <= raw[g];
          s2[g] <= s1[g];
          s3[g] <= s2[g];
        end
      end
    end
  endgenerate

  assign sda_s     = s2[1];
  assign scl_rise  = s2[0] & ~s3[0];
  assign scl_fall  = ~s2[0] & s3[0];
  assign start_det = s2[0] & s3[0] & ~s2[1] & s3[1];
  assign stop_det  = s2[0] & s3[0] & s2[1] & ~s3[1];
endmodule

// File: rtl/i2c24_wordmem.sv
module i2c24_wordmem #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 24,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c24_engine.sv
module i2c24_engine
  import i2c24_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 24,
  localparam int AW    = $clog2(DEPTH),
  localparam int NB    = WORD_W / BYTE_W,
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        my_addr,
  input  logic [WORD_W-1:0] rdata,
  output logic              sda_o,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata,
  output logic [AW-1:0]     ptr
);
  bus_state_t        state, nxt;
  logic [3:0]        cnt;
  logic [7:0]        shreg;
  logic [BW-1:0]     bidx;
  logic [WORD_W-9:0] wbuf;
  logic              mack;
  logic [7:0]        tx_byte;

  always_comb begin
    int lsb;
    lsb = (NB - 1 - int'(bidx)) * BYTE_W;
    tx_byte = rdata[lsb +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      nxt   <= ST_IDLE;
      sda_o <= 1'b1;
      cnt   <= '0;
      shreg <= '0;
      bidx  <= '0;
      wbuf  <= '0;
      mack  <= 1'b0;
      ptr   <= '0;
      we    <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      we <= 1'b0;
      if (stop_det) begin
        state <= ST_IDLE;
        sda_o <= 1'b1;
      end else if (start_det) begin
        state <= ST_ADDR;
        sda_o <= 1'b1;
        cnt   <= '0;
        bidx  <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_WPTR, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[7:1] == my_addr) begin
                    sda_o <= 1'b0;
                    state <= ST_ACK;
                    nxt   <= shreg[0] ? ST_RDAT : ST_WPTR;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                ST_WPTR: begin
                  ptr   <= shreg[AW-1:0];
                  bidx  <= '0;
                  sda_o <= 1'b0;
                  state <= ST_ACK;
                  nxt   <= ST_WDAT;
                end
                default: begin
                  sda_o <= 1'b0;
                  state <= ST_ACK;
                  nxt   <= ST_WDAT;
                  if (int'(bidx) == NB - 1) begin
                    we    <= 1'b1;
                    waddr <= ptr;
                    wdata <= {wbuf, shreg};
                    ptr   <= ptr + 1'b1;
                    bidx  <= '0;
                  end else begin
                    wbuf <= {wbuf[WORD_W-17:0], shreg};
                    bidx <= bidx + 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= nxt;
              cnt   <= '0;
              sda_o <= (nxt == ST_RDAT) ? tx_byte[7] : 1'b1;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_o <= 1'b1;
                state <= ST_RACK;
              end else begin
                sda_o <= tx_byte[3'(7 - int'(cnt))];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (int'(bidx) == NB - 1) begin
                bidx <= '0;
                ptr  <= ptr + 1'b1;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                state <= ST_RDAT;
                sda_o <= tx_byte[7];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c24_bridge.sv
module i2c24_bridge #(
  parameter int DEPTH       = 256,
  parameter int WORD_W      = 24,
  parameter bit NARROW_PINS = 1'b0,
  localparam int STRAP_W    = NARROW_PINS ? 1 : 2,
  localparam int DEV_W      = 7 - STRAP_W,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  input  logic [DEV_W-1:0]   dev_addr,
  input  logic [STRAP_W-1:0] strap
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, word_ptr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic [6:0]        my_addr;

  assign my_addr = {dev_addr, strap};

  i2c24_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c24_engine #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .my_addr   (my_addr),
    .rdata     (mem_rdata),
    .sda_o     (sda_o),
    .we        (mem_we),
    .waddr     (mem_waddr),
    .wdata     (mem_wdata),
    .ptr       (word_ptr)
  );

  i2c24_wordmem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (word_ptr),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/i2c24_bridge_chk.sv
module i2c24_bridge_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_o,
  input logic          start_det,
  input logic          stop_det,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] word_ptr
);
  AST_SDA_RELEASED_AFTER_RST: assert property (@(posedge clk) rst |=> sda_o); // R8
  AST_SDA_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $fell(sda_o) |-> !scl_i); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst) stop_det |=> sda_o); // R7
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst) start_det |=> sda_o); // R7
  AST_WRITE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R3
  AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) mem_we |-> !scl_i); // R3
  AST_PTR_PAST_WRITE: assert property (@(posedge clk) disable iff (rst) mem_we |-> (word_ptr == AW'(mem_waddr + 1'b1))); // R4
endmodule

bind i2c24_bridge i2c24_bridge_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_o     (sda_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .word_ptr  (word_ptr)
);

// File: tb/i2c24_bridge_bench.sv
module i2c24_bridge_bench;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_o;
  logic sda_line;
  logic [4:0] dev_addr = 5'b10110;
  logic [1:0] strap = 2'b01;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [23:0] model [256];

  always #10 clk = ~clk;
  assign sda_line = sda_m & sda_o;

  i2c24_bridge u_i2c24_bridge (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_o    (sda_o),
    .dev_addr (dev_addr),
    .strap    (strap)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q(); ack = ~sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic m_rbyte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
    end
    sda_m = ack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  function automatic logic [6:0] my_addr();
    return {dev_addr, strap};
  endfunction

  function automatic logic [23:0] pattern(input int a, input int salt);
    return 24'((a * 24'h010203) ^ (salt * 24'h5A3C96) ^ 24'hA5C3E1);
  endfunction

  task automatic set_ptr(input logic [7:0] p);
    bit ack;
    m_start();
    m_wbyte({my_addr(), 1'b0}, ack); chk(ack, "R2 address ack", 32'(ack), 1);
    m_wbyte(p, ack); chk(ack, "R3 pointer byte ack", 32'(ack), 1);
  endtask

  task automatic write_words(input int p, input int n, input int salt);
    bit ack;
    logic [23:0] v;
    set_ptr(8'(p));
    for (int w = 0; w < n; w++) begin
      v = pattern((p + w) % 256, salt);
      for (int k = 2; k >= 0; k--) begin
        m_wbyte(v[k*8 +: 8], ack);
        chk(ack, "R3 data byte ack", 32'(ack), 1);
      end
      model[(p + w) % 256] = v;
    end
    m_stop();
  endtask

  task automatic read_cur(input int p, input int n, input string req);
    bit ack;
    logic [7:0] b;
    logic [23:0] got;
    m_start();
    m_wbyte({my_addr(), 1'b1}, ack); chk(ack, "R2 read address ack", 32'(ack), 1);
    for (int w = 0; w < n; w++) begin
      for (int k = 2; k >= 0; k--) begin
        m_rbyte(!(w == n - 1 && k == 0), b);
        got[k*8 +: 8] = b;
      end
      chk(got == model[(p + w) % 256], req, 32'(got), 32'(model[(p + w) % 256]));
    end
  endtask

  task automatic read_words(input int p, input int n, input string req);
    set_ptr(8'(p));
    read_cur(p, n, req);
    m_stop();
  endtask

  initial begin
    repeat (20000 * Q * 2) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_o == 1'b1, "R8 sda released after reset", 32'(sda_o), 1);

    // R1 R2: sweep all 7-bit addresses, only {dev_addr,strap} = 0x59 ACKs
    for (int a = 0; a < 128; a++) begin
      m_start();
      m_wbyte({7'(a), 1'b0}, ack);
      chk(ack == (a == 7'h59), "R1 R2 address sweep", 32'(ack), 32'(a == 7'h59));
      m_stop();
    end
    strap = 2'b10;
    m_start(); m_wbyte({7'h5A, 1'b0}, ack); m_stop();
    chk(ack, "R1 strap change new address", 32'(ack), 1);
    m_start(); m_wbyte({7'h59, 1'b0}, ack); m_stop();
    chk(!ack, "R1 strap change old address", 32'(ack), 0);

    // R3 R6 R9: single words at several locations
    write_words(5, 1, 1);
    write_words(128, 1, 2);
    write_words(200, 2, 3);
    read_words(5, 1, "R3 R6 R9 single word readback");
    read_words(128, 1, "R6 R9 single word readback");
    read_words(200, 2, "R6 two word burst");

    // R4: burst wrapping from 253 through 0
    write_words(253, 6, 4);
    read_words(253, 6, "R4 wrap burst readback");

    // R4: pointer advanced past a read word ended by NACK
    write_words(40, 2, 5);
    read_words(40, 1, "R6 first word");
    read_cur(41, 1, "R4 pointer advanced after read");
    m_stop();

    // R5: partial word at STOP discarded
    write_words(60, 2, 6);
    set_ptr(8'd60);
    m_wbyte(8'h11, ack); m_wbyte(8'h22, ack);
    m_stop();
    read_words(60, 2, "R5 partial word at STOP dropped");

    // R5 R7: partial word at repeated START dropped, read begins at word 60 upper byte
    set_ptr(8'd60);
    m_wbyte(8'h33, ack);
    read_cur(60, 1, "R5 R7 repeated start read");
    m_stop();

    // R6: after master NACK the slave keeps SDA released
    set_ptr(8'd5);
    m_start(); m_wbyte({my_addr(), 1'b1}, ack);
    m_rbyte(1'b0, b);
    chk(b == model[5][23:16], "R6 upper byte", 32'(b), 32'(model[5][23:16]));
    m_rbyte(1'b0, b);
    chk(b == 8'hFF, "R6 released after NACK", 32'(b), 32'hFF);
    m_stop();

    // R2: mismatched address ignores following bytes
    m_start();
    m_wbyte({7'h22, 1'b0}, ack);
    m_wbyte(8'd70, ack);
    chk(!ack, "R2 ignored byte not acked", 32'(ack), 0);
    m_wbyte(8'h00, ack); m_wbyte(8'h00, ack); m_wbyte(8'h00, ack);
    m_stop();
    write_words(71, 1, 7);
    model[70] = 24'h0;
    write_words(70, 1, 8);
    m_start();
    m_wbyte({7'h22, 1'b0}, ack);
    m_wbyte(8'd70, ack); m_wbyte(8'h00, ack); m_wbyte(8'h00, ack); m_wbyte(8'h00, ack);
    m_stop();
    read_words(70, 2, "R2 R9 mismatch wrote nothing");

    chk(sda_o == 1'b1, "R8 sda released when idle", 32'(sda_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule